// File: doc/BRIEF.md
# DDR Burst-of-Two SRAM Port

This block is a synthesizable model of a pipelined synchronous SRAM. Its data interface runs at double data rate, and every access moves a fixed burst of two words. One address bus carries both reads and writes. The bus is sampled on each rising edge of the input clock K. Each rising edge accepts at most one command, so a read and a write each use one K cycle of address bandwidth. Write data is captured on both edges of K: the rising edge of K and the rising edge of its complement, which is the falling edge of K. Read data is launched on both edges of K. This is the mode in which the separate output clocks are tied off.

A one-bit burst counter sets the order of the two words. In the 8-bit configuration the whole address names a word pair, and a burst always starts at word 0. In the 18- and 36-bit configurations, address bit 0 selects the starting word and the burst wraps to the other word of the pair. A write completes inside the block once both of its words are in. A read that arrives while a write to the same pair is still staged takes the staged data through a bypass. A small register array stands in for the memory core.

Top module: `ddr_burst2_sram`

## Requirements
- R1: When wr_n_i is low and rd_n_i is high at K rising edge t, the block accepts a write to addr_i. Its first data word is taken from wdata_i at K rising edge t+1 and its second at the K falling edge that follows.
- R2: When rd_n_i is low at K rising edge t, rvalid_o is high from the K falling edge after edge t+1 until the K falling edge after edge t+2. During the low phase of K, rdata_o carries the first burst word. During the following high phase it carries the second.
- R3: With DW of 18 or 36, address bit 0 selects the starting word of the pair (0 for even, 1 for odd). The second word is the other word of the same pair, for both writes and reads.
- R4: With DW of 8, the full address selects a pair and a burst always starts at word 0. A read therefore returns the two words in the order they were written.
- R5: A read that is accepted on the K rising edge right after a write to the same pair returns the data of that write.
- R6: When both selects are low on the same edge, only the read is accepted. The write is dropped and the array keeps its old contents.
- R7: An edge with both selects high is a no-op. Two edges later rvalid_o stays low for the whole cycle, and no stored data changes.
- R8: Reads and writes may be issued on every K rising edge in any mix, and each read returns the data of all writes accepted before it.
- R9: While rst_ni is low, rvalid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k_i | input | 1 | Input clock K; its falling edge stands for the complement clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_n_i | input | 1 | Read select, active low |
| wr_n_i | input | 1 | Write select, active low |
| addr_i | input | AW | Shared command address |
| wdata_i | input | DW | Write data, one word per K edge |
| rdata_o | output | DW | Read data, one word per K phase |
| rvalid_o | output | 1 | High while rdata_o carries a burst word |

## Verification
The assertions assume that K toggles with a steady duty cycle and that the selects, the address and the write data are settled and known around each edge that samples them. The write staging and the read pipeline count whole K cycles, so the latency properties hold only under those conditions. The stimulus changes every input 1 ns after a K edge, well clear of the next one. It loads each write word into the half cycle before the edge that captures it. Two instances, one 18 bits wide and one 8 bits wide, share the same command stream, so the burst-order rules of both widths are checked against one reference model.

// File: rtl/b2_pkg.sv
package b2_pkg;
  localparam int BURST_WORDS = 2;

  // 1 when the address LSB seeds the burst counter
  function automatic int start_bits(input int dw);
    return (dw == 8) ? 0 : 1;
  endfunction
endpackage

// File: rtl/b2_core_array.sv
module b2_core_array
  import b2_pkg::*;
#(
  parameter int DW = 18,
  parameter int PW = 5
) (
  input  logic                            k_i,
  input  logic                            we_i,
  input  logic [PW-1:0]                   wpair_i,
  input  logic [BURST_WORDS-1:0][DW-1:0]  wdata_i,
  input  logic [PW-1:0]                   rpair_i,
  output logic [BURST_WORDS-1:0][DW-1:0]  rdata_o
);
  localparam int DEPTH = 1 << PW;

  for (genvar b = 0; b < BURST_WORDS; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge k_i) begin
      if (we_i) mem[wpair_i] <= wdata_i[b];
    end

    assign rdata_o[b] = mem[rpair_i];
  end
endmodule

// File: rtl/b2_wr_stage.sv
module b2_wr_stage
  import b2_pkg::*;
#(
  parameter int DW = 18,
  parameter int PW = 5
) (
  input  logic                            k_i,
  input  logic                            rst_ni,
  input  logic                            go_i,
  input  logic [PW-1:0]                   pair_i,
  input  logic                            start_i,
  input  logic [DW-1:0]                   wdata_i,
  output logic                            commit_o,
  output logic [PW-1:0]                   cpair_o,
  output logic [BURST_WORDS-1:0][DW-1:0]  cdata_o
);
  logic          wa_v, st_v;
  logic [PW-1:0] wa_pair, st_pair;
  logic          wa_start, st_start;
  logic [DW-1:0] st_w0, st_w1;

  always_ff @(posedge k_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wa_v <= 1'b0;
      st_v <= 1'b0;
    end else begin
      wa_v <= go_i;
      st_v <= wa_v;
    end
  end

  always_ff @(posedge k_i) begin
    if (go_i) begin
      wa_pair  <= pair_i;
      wa_start <= start_i;
    end
    if (wa_v) begin
      st_pair  <= wa_pair;
      st_start <= wa_start;
      st_w0    <= wdata_i;
    end
  end

  // second word rides the complement edge
  always_ff @(negedge k_i) begin
    if (st_v) st_w1 <= wdata_i;
  end

  assign commit_o   = st_v;
  assign cpair_o    = st_pair;
  assign cdata_o[0] = st_start ? st_w1 : st_w0;
  assign cdata_o[1] = st_start ? st_w0 : st_w1;

  AST_WR_COMMIT: assert property (@(posedge k_i) disable iff (!rst_ni)
    go_i |-> ##2 commit_o); // R1
  AST_COMMIT_ADDR_KNOWN: assert property (@(posedge k_i) disable iff (!rst_ni)
    commit_o |-> !$isunknown(cpair_o)); // R1
endmodule

// File: rtl/b2_rd_launch.sv
module b2_rd_launch #(
  parameter int DW = 18
) (
  input  logic          k_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [DW-1:0] w0_i,
  input  logic [DW-1:0] w1_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic          v_neg, v_pos;
  logic [DW-1:0] q_neg, q_pos;

  always_ff @(negedge k_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_neg <= 1'b0;
      q_neg <= '0;
    end else begin
      v_neg <= fire_i;
      q_neg <= w0_i;
    end
  end

  always_ff @(posedge k_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_pos <= 1'b0;
      q_pos <= '0;
    end else begin
      v_pos <= fire_i;
      q_pos <= w1_i;
    end
  end

  // low phase carries word 0, high phase word 1
  assign rvalid_o = k_i ? v_pos : v_neg;
  assign rdata_o  = k_i ? q_pos : q_neg;
endmodule

// File: rtl/ddr_burst2_sram.sv
module ddr_burst2_sram
  import b2_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic          k_i,
  input  logic          rst_ni,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  localparam int SB = start_bits(DW);
  localparam int PW = AW - SB;

  logic          rd_go, wr_go;
  logic [PW-1:0] cmd_pair;
  logic          cmd_start;

  assign rd_go = !rd_n_i;
  assign wr_go = !wr_n_i && rd_n_i; // read wins a shared edge

  if (SB == 1) begin : g_wide
    assign cmd_pair  = addr_i[AW-1:1];
    assign cmd_start = addr_i[0];
  end else begin : g_narrow
    assign cmd_pair  = addr_i;
    assign cmd_start = 1'b0;
  end

  logic                           commit;
  logic [PW-1:0]                  cpair;
  logic [BURST_WORDS-1:0][DW-1:0] cdata, arr_rd, src;

  b2_wr_stage #(.DW(DW), .PW(PW)) u_wr (
    .k_i     (k_i),
    .rst_ni  (rst_ni),
    .go_i    (wr_go),
    .pair_i  (cmd_pair),
    .start_i (cmd_start),
    .wdata_i (wdata_i),
    .commit_o(commit),
    .cpair_o (cpair),
    .cdata_o (cdata)
  );

  logic          rd_p1, rd_p2;
  logic [PW-1:0] rd_pair1;
  logic          rd_start1;
  logic [DW-1:0] rd_w0, rd_w1;

  b2_core_array #(.DW(DW), .PW(PW)) u_arr (
    .k_i    (k_i),
    .we_i   (commit),
    .wpair_i(cpair),
    .wdata_i(cdata),
    .rpair_i(rd_pair1),
    .rdata_o(arr_rd)
  );

  // staged write not yet in the array
  assign src = (commit && (cpair == rd_pair1)) ? cdata : arr_rd;

  always_ff @(posedge k_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_p1 <= 1'b0;
      rd_p2 <= 1'b0;
    end else begin
      rd_p1 <= rd_go;
      rd_p2 <= rd_p1;
    end
  end

  always_ff @(posedge k_i) begin
    if (rd_go) begin
      rd_pair1  <= cmd_pair;
      rd_start1 <= cmd_start;
    end
    if (rd_p1) begin
      rd_w0 <= src[rd_start1];
      rd_w1 <= src[~rd_start1];
    end
  end

  b2_rd_launch #(.DW(DW)) u_rd (
    .k_i     (k_i),
    .rst_ni  (rst_ni),
    .fire_i  (rd_p2),
    .w0_i    (rd_w0),
    .w1_i    (rd_w1),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );

  AST_RD_LATENCY: assert property (@(posedge k_i) disable iff (!rst_ni)
    !rd_n_i |-> ##2 rvalid_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge k_i) disable iff (!rst_ni)
    rd_n_i |-> ##2 !rvalid_o); // R7
  AST_RD_PRIORITY: assert property (@(posedge k_i) disable iff (!rst_ni)
    !rd_n_i |-> ##2 !commit); // R6
  AST_RST_QUIET: assert property (@(posedge k_i)
    !rst_ni |-> !rvalid_o); // R9
endmodule

// File: tb/ddr_burst2_sram_test.sv
`timescale 1ns/1ps
module ddr_burst2_sram_test;
  localparam int AW = 6;

  logic        k_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_n_i = 1'b1, wr_n_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [17:0] wdata_i = '0;
  logic [17:0] rdata_o;
  logic [7:0]  rdata8;
  logic        rvalid_o, rvalid8;

  always #2 k_i = ~k_i; // 250 MHz

  ddr_burst2_sram #(.DW(18), .AW(AW)) uut (
    .k_i(k_i), .rst_ni(rst_ni), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o));

  ddr_burst2_sram #(.DW(8), .AW(AW)) uut8 (
    .k_i(k_i), .rst_ni(rst_ni), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .addr_i(addr_i), .wdata_i(wdata_i[7:0]), .rdata_o(rdata8), .rvalid_o(rvalid8));

  int total = 0, bad = 0;

  typedef struct {
    logic [17:0] e0, e1;
    logic [7:0]  f0, f1;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [17:0] m18 [64];
  logic [7:0]  m8  [128];

  task automatic chk(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  bit          pw_v = 0;
  logic [17:0] pw_d1 = '0;

  task automatic drive_cmd(input bit rd, input bit wr, input int a,
                           input logic [17:0] d0, input logic [17:0] d1, input string tag);
    exp_t e;
    bit   wr_ok;
    rd_n_i = !rd;
    wr_n_i = !wr;
    addr_i = a[AW-1:0];
    wr_ok  = wr && !rd; // R6: read wins
    if (rd) begin
      e.e0 = m18[a]; e.e1 = m18[a ^ 1];
      e.f0 = m8[2*a]; e.f1 = m8[2*a + 1];
      e.tag = tag;
      sb.push_back(e);
    end
    if (wr_ok) begin
      m18[a] = d0; m18[a ^ 1] = d1;          // R3 wrap
      m8[2*a] = d0[7:0]; m8[2*a + 1] = d1[7:0]; // R4 fixed start
    end
    @(posedge k_i); #1;
    wdata_i = pw_v ? pw_d1 : '0;  // second word of previous write
    pw_v  = wr_ok;
    pw_d1 = d1;
    @(negedge k_i); #1;
    wdata_i = wr_ok ? d0 : '0;    // first word of this write
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_cmd(0, 0, 0, '0, '0, "R7");
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge k_i); #1;
      if (rvalid_o || rvalid8) begin
        if (sb.size() == 0) begin
          chk(0, "R2", {17'b0, rvalid_o}, 18'd0);
        end else begin
          e = sb.pop_front();
          chk(rvalid_o && rdata_o == e.e0, e.tag, rdata_o, e.e0);
          chk(rvalid8 && rdata8 == e.f0, e.tag, {10'b0, rdata8}, {10'b0, e.f0});
          @(posedge k_i); #1;
          chk(rvalid_o && rdata_o == e.e1, e.tag, rdata_o, e.e1);
          chk(rvalid8 && rdata8 == e.f1, e.tag, {10'b0, rdata8}, {10'b0, e.f1});
        end
      end
    end
  end

  bit done = 0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #5;
    chk(!rvalid_o && !rvalid8, "R9", {17'b0, rvalid_o}, 18'd0);
    @(negedge k_i); #1;
    chk(!rvalid_o && !rvalid8, "R9", {17'b0, rvalid8}, 18'd0);
    rst_ni = 1'b1;

    // R1: fill every address
    for (int a = 0; a < 64; a++)
      drive_cmd(0, 1, a, 18'h0A000 | 18'(a * 3), 18'h05000 | 18'(a * 5 + 1), "R1");

    // R2/R3/R4: back-to-back reads, even and odd starts
    for (int a = 0; a < 10; a++)
      drive_cmd(1, 0, a, '0, '0, (a % 2) ? "R3" : "R4");
    idle(1);
    for (int a = 41; a > 33; a -= 3)
      drive_cmd(1, 0, a, '0, '0, "R2");

    // R5: read right after write to the same pair
    drive_cmd(0, 1, 7, 18'h3C3C1, 18'h1E1E2, "R5");
    drive_cmd(1, 0, 7, '0, '0, "R5");
    drive_cmd(0, 1, 12, 18'h22221, 18'h11112, "R5");
    drive_cmd(1, 0, 13, '0, '0, "R5");
    drive_cmd(1, 0, 12, '0, '0, "R5");

    // R8: mixed traffic every edge
    for (int i = 0; i < 12; i++) begin
      int a = (i * 7 + 3) % 64;
      if (i % 3 == 2) drive_cmd(1, 0, (a + 60) % 64, '0, '0, "R8");
      else            drive_cmd(0, 1, a, 18'(i * 1111 + 5), 18'(i * 2222 + 9), "R8");
      drive_cmd(1, 0, a ^ 1, '0, '0, "R8");
    end

    // R6: both selects low, write dropped
    drive_cmd(1, 1, 20, 18'h3FFFF, 18'h3FFFE, "R6");
    idle(2);
    drive_cmd(1, 0, 20, '0, '0, "R6");
    drive_cmd(1, 0, 21, '0, '0, "R6");

    // R7: idle edges give no valid and change nothing
    idle(4);
    for (int i = 0; i < 3; i++) begin
      drive_cmd(0, 0, 33, 18'h12345, 18'h2AAAA, "R7");
      chk(!rvalid_o && !rvalid8, "R7", {17'b0, rvalid_o}, 18'd0);
      @(posedge k_i); #1;
      chk(!rvalid_o && !rvalid8, "R7", {17'b0, rvalid8}, 18'd0);
      @(negedge k_i); #1;
    end
    drive_cmd(1, 0, 33, '0, '0, "R7");
    drive_cmd(1, 0, 32, '0, '0, "R7");
    idle(5);
    chk(sb.size() == 0, "R2", 18'(sb.size()), 18'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule